// File: doc/BRIEF.md
# Fault Status Latch with Serial Readback

This block keeps a snapshot of a per-channel fault vector and returns it over a serial shift chain that can be daisy-chained with neighbouring devices. A load strobe with the path select in status position takes the snapshot on its rising edge. For as long as the strobe then stays high, the snapshot holds every stage of the shift chain at its value, and the serial clock and serial data input have no effect. The serial output shows the highest channel during this time.

Once the strobe falls, the forced values remain in the chain and the snapshot is cut off from it. Each rising edge of the serial clock then moves the next lower channel to the serial output, while the serial input enters at the low end. The strobe has to stay low until every channel has been clocked out.

All external inputs are sampled by a faster system clock through a synchronizer. Edges of the serial clock and of the strobe are found from the synchronized copies. A strobe edge in status position while the outputs-off input is high still takes a snapshot, and a one-cycle flag marks that capture as taken while the outputs were off.

Top module: `fault_status_readback`

## Requirements
- R1: After reset, `ser_out` is 0 and `blank_capture` is 0.
- R2: With `path_sel` = 0 (status position), a rising edge of `load_strobe` copies `fault_live` into the snapshot. While `load_strobe` stays high, `ser_out` shows snapshot bit N_CH-1.
- R3: After a capture, changes on `fault_live` do not alter the snapshot or the values later read out.
- R4: While `load_strobe` is high after a status capture, rising edges on `ser_clk` and the level of `ser_in` have no effect. `ser_out` stays on bit N_CH-1, and the later readout equals the captured vector.
- R5: After `load_strobe` falls, `ser_out` first shows bit N_CH-1. Each `ser_clk` rising edge then presents the next lower bit, so the order is N_CH-1 down to 0.
- R6: On each `ser_clk` rising edge outside the forced period, `ser_in` enters at bit 0. After N_CH edges, the first bit shifted in appears on `ser_out`.
- R7: With `path_sel` = 1 (data position), a `load_strobe` edge neither captures nor forces. The shift chain keeps its contents.
- R8: A status capture whose strobe edge arrives while `outputs_off` = 1 raises `blank_capture` for exactly one system clock, and the capture is still made. With `outputs_off` = 0, or in data position, the flag stays low.
- R9: Each input reaches the logic through SYNC_STAGES synchronizer flops. An edge takes effect on the next clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, rising-edge active |
| ser_in | input | 1 | Serial data input, enters at bit 0 |
| load_strobe | input | 1 | Snapshot and force strobe |
| path_sel | input | 1 | 0 = status position, 1 = data position |
| outputs_off | input | 1 | Outputs-off level, marks a capture as taken while off |
| fault_live | input | N_CH | Live per-channel fault vector |
| ser_out | output | 1 | Serial output, highest chain bit |
| blank_capture | output | 1 | One-cycle flag: capture taken with outputs off |

## Verification
The capture path is driven with sparse, dense, alternating, all-zero and all-one vectors. Each of these is followed by a change of `fault_live` while the strobe is high. A wrong bit order, a stuck bit, or a snapshot that still follows the live vector would each corrupt the readout. Serial clocks and a high `ser_in` applied during the forced period separate a chain that is truly held from one that shifts. A word fed in during readout shows whether the input enters at bit 0 and how many stages lie in the chain. Strobe edges in data position, and with outputs off in status position, separate a capture that is gated from one that is only flagged.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } path_e;

  function automatic logic rose(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fell(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fsr_status_latch.sv
module fsr_status_latch
  import fsr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_s,
  input  logic         path_s,
  input  logic         off_s,
  input  logic [N-1:0] fault_s,
  output logic         cap_evt,
  output logic         force_on,
  output logic         force_req,
  output logic [N-1:0] force_vec,
  output logic [N-1:0] status_q,
  output logic         blank_capture
);
  logic strobe_d;

  assign cap_evt   = rose(strobe_s, strobe_d) && (path_e'(path_s) == SEL_STATUS);
  assign force_req = cap_evt | force_on;
  assign force_vec = cap_evt ? fault_s : status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_d      <= 1'b0;
      force_on      <= 1'b0;
      status_q      <= '0;
      blank_capture <= 1'b0;
    end else begin
      strobe_d      <= strobe_s;
      blank_capture <= cap_evt & off_s;
      if (cap_evt) begin
        status_q <= fault_s;
        force_on <= 1'b1;
      end else if (fell(strobe_s, strobe_d)) begin
        force_on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsr_shift_chain.sv
module fsr_shift_chain
  import fsr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sin_s,
  input  logic         force_req,
  input  logic [N-1:0] force_vec,
  output logic         shift_evt,
  output logic [N-1:0] sr
);
  logic sclk_d;

  function automatic logic [N-1:0] shift_next(input logic [N-1:0] v, input logic b);
    return {v[N-2:0], b};
  endfunction

  assign shift_evt = rose(sclk_s, sclk_d) && !force_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sr     <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (force_req)      sr <= force_vec;
      else if (shift_evt) sr <= shift_next(sr, sin_s);
    end
  end
endmodule

// File: rtl/fault_status_readback.sv
module fault_status_readback #(
  parameter int N_CH        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            ser_in,
  input  logic            load_strobe,
  input  logic            path_sel,
  input  logic            outputs_off,
  input  logic [N_CH-1:0] fault_live,
  output logic            ser_out,
  output logic            blank_capture
);
  localparam int CTRL_W = 5;
  localparam int SYNC_W = N_CH + CTRL_W;

  logic [SYNC_W-1:0] sync_q;
  logic              sclk_s, sin_s, strobe_s, path_s, off_s;
  logic [N_CH-1:0]   fault_s;

  // R9: every input crosses the same synchronizer depth
  fsr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({ser_clk, ser_in, load_strobe, path_sel, outputs_off, fault_live}),
    .q   (sync_q)
  );
  assign {sclk_s, sin_s, strobe_s, path_s, off_s, fault_s} = sync_q;

  logic            cap_evt, force_on, force_req, shift_evt;
  logic [N_CH-1:0] force_vec, status_q, sr;

  fsr_status_latch #(.N(N_CH)) u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe_s      (strobe_s),
    .path_s        (path_s),
    .off_s         (off_s),
    .fault_s       (fault_s),
    .cap_evt       (cap_evt),
    .force_on      (force_on),
    .force_req     (force_req),
    .force_vec     (force_vec),
    .status_q      (status_q),
    .blank_capture (blank_capture)
  );

  fsr_shift_chain #(.N(N_CH)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .sin_s     (sin_s),
    .force_req (force_req),
    .force_vec (force_vec),
    .shift_evt (shift_evt),
    .sr        (sr)
  );

  assign ser_out = sr[N_CH-1];
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cap_evt,
  input logic         force_on,
  input logic         shift_evt,
  input logic         off_s,
  input logic [N-1:0] status_q,
  input logic [N-1:0] sr,
  input logic         ser_out,
  input logic         blank_capture
);
  // R3, R7: snapshot changes only on a status capture
  assert_snapshot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(status_q));

  // R4: held chain keeps the top bit steady
  assert_forced_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> $stable(ser_out));

  // R5: a shift moves the next lower bit to the output
  assert_shift_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> ser_out == $past(sr[N-2]));

  // R4: no shift while held
  assert_no_shift_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |-> !shift_evt);

  // R8: flag follows a capture with outputs off
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && off_s |=> blank_capture);

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_capture |-> $past(cap_evt) && $past(off_s));

  assert_flag_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_capture |=> !blank_capture);
endmodule

bind fault_status_readback fsr_checker #(.N(N_CH)) u_fsr_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cap_evt       (cap_evt),
  .force_on      (force_on),
  .shift_evt     (shift_evt),
  .off_s         (off_s),
  .status_q      (status_q),
  .sr            (sr),
  .ser_out       (ser_out),
  .blank_capture (blank_capture)
);

// File: tb/test_fault_status_readback.sv
module test_fault_status_readback;
  localparam int N = 16;
  localparam int SETTLE = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_clk = 1'b0, ser_in = 1'b0, load_strobe = 1'b0;
  logic         path_sel = 1'b0, outputs_off = 1'b0;
  logic [N-1:0] fault_live = '0;
  logic         ser_out, blank_capture;

  int tests = 0;
  int fails = 0;
  int flag_cnt;

  always #4 clk = ~clk;

  fault_status_readback #(.N_CH(N), .SYNC_STAGES(2)) i_fault_status_readback (
    .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_in (ser_in),
    .load_strobe (load_strobe), .path_sel (path_sel), .outputs_off (outputs_off),
    .fault_live (fault_live), .ser_out (ser_out), .blank_capture (blank_capture)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // waits SETTLE negedges, counting flag cycles
  task automatic settle();
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      if (blank_capture) flag_cnt++;
    end
  endtask

  task automatic sclk_pulse(input logic din);
    ser_in = din;
    ser_clk = 1'b1;
    settle();
    ser_clk = 1'b0;
    settle();
  endtask

  // reads N bits MSB first, feeding word w in at the low end
  task automatic readout(input logic [N-1:0] w, output logic [N-1:0] got);
    for (int i = N - 1; i >= 0; i--) begin
      got[i] = ser_out;
      sclk_pulse(w[i]);
    end
    ser_in = 1'b0;
  endtask

  task automatic capture(input logic [N-1:0] pat, input logic path, input logic off);
    path_sel = path;
    outputs_off = off;
    fault_live = pat;
    settle();
    flag_cnt = 0;
    load_strobe = 1'b1;
    settle();
    settle();
  endtask

  task automatic t_reset();
    check("R1 ser_out", ser_out, 0);
    check("R1 blank_capture", blank_capture, 0);
  endtask

  task automatic t_capture(input logic [N-1:0] pat);
    logic [N-1:0] got;
    capture(pat, 1'b0, 1'b0);
    check("R2 top bit while strobe high", ser_out, pat[N-1]);
    fault_live = ~pat;
    settle();
    check("R3 live change ignored", ser_out, pat[N-1]);
    for (int k = 0; k < 3; k++) sclk_pulse(1'b1);
    check("R4 clocks ignored while held", ser_out, pat[N-1]);
    load_strobe = 1'b0;
    settle();
    check("R5 top bit after release", ser_out, pat[N-1]);
    readout('0, got);
    check("R5 R3 R4 readout order", got, pat);
    check("R8 no flag with outputs on", flag_cnt, 0);
  endtask

  task automatic t_chain(input logic [N-1:0] pat, input logic [N-1:0] w);
    logic [N-1:0] got;
    capture(pat, 1'b0, 1'b0);
    load_strobe = 1'b0;
    settle();
    readout(w, got);
    check("R5 first pass", got, pat);
    readout('0, got);
    check("R6 shifted-in word", got, w);
  endtask

  task automatic t_data_mode(input logic [N-1:0] w);
    logic [N-1:0] got;
    logic [N-1:0] dummy;
    path_sel = 1'b0;
    readout(w, dummy);
    capture(~w, 1'b1, 1'b1);
    sclk_pulse(1'b0);
    load_strobe = 1'b0;
    settle();
    path_sel = 1'b0;
    check("R7 no flag in data position", flag_cnt, 0);
    readout('0, got);
    check("R7 chain kept across strobe", got, {w[N-2:0], 1'b0});
  endtask

  task automatic t_blank(input logic [N-1:0] pat);
    logic [N-1:0] got;
    capture(pat, 1'b0, 1'b1);
    check("R8 one flag cycle", flag_cnt, 1);
    load_strobe = 1'b0;
    outputs_off = 1'b0;
    settle();
    readout('0, got);
    check("R8 capture still made", got, pat);
  endtask

  task automatic t_latency();
    // R9: strobe edge seen after 2 sync flops plus one decision clock
    capture(16'h8000, 1'b0, 1'b0);
    load_strobe = 1'b0;
    settle();
    @(negedge clk);
    load_strobe = 1'b1;
    fault_live = 16'h0000;
    outputs_off = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 no change before sync delay", ser_out, 1);
    @(negedge clk);
    check("R9 capture after sync delay", ser_out, 0);
    check("R9 flag on same clock", blank_capture, 1);
    load_strobe = 1'b0;
    outputs_off = 1'b0;
    settle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture(16'hA5C3);
    t_capture(16'h8001);
    t_capture(16'h0000);
    t_capture(16'hFFFF);
    t_capture(16'h5555);
    t_chain(16'h0F0F, 16'hB26D);
    t_data_mode(16'hC3A9);
    t_blank(16'h7E18);
    t_latency();
    finish_run();
  end
endmodule